// File: doc/BRIEF.md
# Two-Way Set-Associative Byte Cache with Single-Bit Replacement

This block is a write-back, write-allocate cache with two ways per set, sitting between a byte-wide processor port and a block-wide memory port. A request address is split into a tag, a set number and a byte offset. Both ways of the addressed set are compared against the tag in the same cycle, and the byte of the matching way is selected through a multiplexer.

On a miss a victim way is chosen. An empty way is taken first, with way 0 preferred when both are empty. When both ways hold data, the way named by a per-set replacement bit is taken. A modified victim is copied back to memory before the new block is fetched. The fetched block is installed and the lookup is repeated, so every access, whether it hit at once or after a refill, finishes through the same hit path. Each completed access points the set's replacement bit at the way it did not touch.

The controller has four states. IDLE accepts a request (IDLE to LOOKUP). LOOKUP either finishes on a hit (LOOKUP to IDLE) or starts a refill, going to WBACK when the victim is valid and modified and to FILL otherwise. WBACK goes to FILL on the memory acknowledge. FILL installs the block on the acknowledge and goes back to LOOKUP.

Top module: `cache2w_top`

## Requirements
- R1: With the default parameters, address bits [2:0] select the byte in the block, bits [11:3] select one of 512 sets, and bits [31:12] form the tag. Two blocks with the same set bits and different tags can be held at the same time, one in each way.
- R2: A request taken in IDLE (cpu_req high while cpu_ready is high) is looked up in the next cycle. On a hit, cpu_done and cpu_hit are high for exactly that one cycle, and on a read cpu_rdata carries the addressed byte of the matching way.
- R3: After reset every way of every set is empty and not modified, and all replacement bits are 0. cpu_ready is high, and mem_req and cpu_done are low. The first access to any address is a miss, whatever the stale tag contents.
- R4: A miss fetches the whole block with mem_we low and mem_addr equal to request address bits [31:3]. The lookup that follows hits, and cpu_done then comes with cpu_hit low.
- R5: A write hit updates only the addressed byte and marks the line modified, with no memory traffic. A write miss first fetches the block and then writes the byte into it.
- R6: On a miss, an empty way of the set is chosen as victim before a filled one. When both ways are empty, way 0 is chosen.
- R7: When both ways are filled, the victim is the way named by the set's replacement bit (0 selects way 0, 1 selects way 1). After every completed access the bit names the other way from the one accessed.
- R8: A valid, modified victim is written to memory (mem_we high, mem_addr equal to its tag and set, mem_wdata equal to its block) before the fetch of the new block starts. A clean or empty victim is never written back.
- R9: At most one way of a set matches a given tag at any time.
- R10: Once mem_req is raised, it stays high with mem_addr and mem_we unchanged until mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Access request, taken while cpu_ready is high |
| cpu_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 8 | Byte to write |
| cpu_ready | output | 1 | Controller is idle and can take a request |
| cpu_done | output | 1 | One-cycle pulse when the access completes |
| cpu_hit | output | 1 | With cpu_done: the access hit on its first lookup |
| cpu_rdata | output | 8 | With cpu_done on a read: the addressed byte |
| mem_req | output | 1 | Block transfer request |
| mem_we | output | 1 | 1 = write back a block, 0 = fetch a block |
| mem_addr | output | 29 | Block address (byte address bits [31:3]) |
| mem_wdata | output | 64 | Block being written back |
| mem_ack | input | 1 | Transfer complete; mem_rdata is valid on a fetch |
| mem_rdata | input | 64 | Fetched block |

## Verification
The hardest case to reach from the ports is a modified victim that is also the least recently used way of a full set. Reaching it needs a set filled with two different tags, a write to one of them, an access to the other so that the replacement bit moves onto the modified way, and then a third tag in the same set. The directed part of the stimulus builds exactly this chain on one set. A random phase then confines addresses to three sets and six tags so that full sets, modified victims and re-fetches of written-back blocks happen many times. Each response and each memory write is compared against the bench's own behavioural model.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_WBACK  = 2'd2,
        ST_FILL   = 2'd3
    } cstate_e;

    localparam int unsigned NUM_WAYS = 2;

endpackage

// File: rtl/c2w_way.sv
module c2w_way #(
    parameter int unsigned SETS  = 512,
    parameter int unsigned TAG_W = 20,
    parameter int unsigned OFF_W = 3,
    parameter int unsigned BLK_W = 64,
    localparam int unsigned SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             fill_i,
    input  logic [BLK_W-1:0] fill_data_i,
    input  logic             wr_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [7:0]       byte_i,
    output logic             hit_o,
    output logic             valid_o,
    output logic             dirty_o,
    output logic [TAG_W-1:0] tag_o,
    output logic [BLK_W-1:0] blk_o
);

    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic [BLK_W-1:0] blk_q [SETS];

    // line state bits: cleared by reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_i) begin
            valid_q[set_i] <= 1'b1;
            dirty_q[set_i] <= 1'b0;
        end else if (wr_i) begin
            dirty_q[set_i] <= 1'b1;
        end
    end

    // tag and data arrays: no reset, guarded by the valid bits
    always_ff @(posedge clk) begin
        if (fill_i) begin
            tag_q[set_i] <= tag_i;
            blk_q[set_i] <= fill_data_i;
        end else if (wr_i) begin
            blk_q[set_i][{off_i, 3'b000} +: 8] <= byte_i;
        end
    end

    assign valid_o = valid_q[set_i];
    assign dirty_o = dirty_q[set_i];
    assign tag_o   = tag_q[set_i];
    assign blk_o   = blk_q[set_i];
    assign hit_o   = valid_q[set_i] && (tag_q[set_i] == tag_i);

endmodule

// File: rtl/c2w_lru.sv
module c2w_lru #(
    parameter int unsigned SETS = 512,
    localparam int unsigned SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_i,
    input  logic             v0_i,
    input  logic             v1_i,
    input  logic             touch_i,
    input  logic             touch_way_i,
    output logic             victim_o
);

    logic [SETS-1:0] lru_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else if (touch_i) begin
            lru_q[set_i] <= ~touch_way_i;
        end
    end

    // empty way first (way 0 preferred), else the least recently used one
    always_comb begin
        if (!v0_i) begin
            victim_o = 1'b0;
        end else if (!v1_i) begin
            victim_o = 1'b1;
        end else begin
            victim_o = lru_q[set_i];
        end
    end

endmodule

// File: rtl/c2w_ctrl.sv
module c2w_ctrl
    import cache2w_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cpu_req_i,
    input  logic    any_hit_i,
    input  logic    victim_i,
    input  logic    vict_dirty_i,
    input  logic    mem_ack_i,
    output cstate_e state_o,
    output logic    ready_o,
    output logic    accept_o,
    output logic    done_o,
    output logic    first_hit_o,
    output logic    vict_way_o,
    output logic    mem_req_o,
    output logic    mem_we_o,
    output logic    fill_o
);

    cstate_e state_q, state_d;
    logic    missed_q;
    logic    vict_q;
    logic    miss_now;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cpu_req_i) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (any_hit_i)         state_d = ST_IDLE;
                else if (vict_dirty_i) state_d = ST_WBACK;
                else                   state_d = ST_FILL;
            end
            ST_WBACK:  if (mem_ack_i) state_d = ST_FILL;
            ST_FILL:   if (mem_ack_i) state_d = ST_LOOKUP;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready_o   = 1'b0;
        accept_o  = 1'b0;
        done_o    = 1'b0;
        miss_now  = 1'b0;
        mem_req_o = 1'b0;
        mem_we_o  = 1'b0;
        fill_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready_o  = 1'b1;
                accept_o = cpu_req_i;
            end
            ST_LOOKUP: begin
                done_o   = any_hit_i;
                miss_now = !any_hit_i;
            end
            ST_WBACK: begin
                mem_req_o = 1'b1;
                mem_we_o  = 1'b1;
            end
            ST_FILL: begin
                mem_req_o = 1'b1;
                fill_o    = mem_ack_i;
            end
            default: ;
        endcase
    end

    // remembers whether this access has missed, and which way it replaces
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            missed_q <= 1'b0;
            vict_q   <= 1'b0;
        end else if (accept_o) begin
            missed_q <= 1'b0;
        end else if (miss_now) begin
            missed_q <= 1'b1;
            vict_q   <= victim_i;
        end
    end

    assign state_o     = state_q;
    assign vict_way_o  = vict_q;
    assign first_hit_o = done_o && !missed_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R2

endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
    import cache2w_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned SETS        = 512,
    parameter int unsigned BLOCK_BYTES = 8,
    localparam int unsigned OFF_W   = $clog2(BLOCK_BYTES),
    localparam int unsigned SET_W   = $clog2(SETS),
    localparam int unsigned TAG_W   = ADDR_W - SET_W - OFF_W,
    localparam int unsigned BLK_W   = BLOCK_BYTES * 8,
    localparam int unsigned BADDR_W = ADDR_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [7:0]         cpu_wdata,
    output logic               cpu_ready,
    output logic               cpu_done,
    output logic               cpu_hit,
    output logic [7:0]         cpu_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [BADDR_W-1:0] mem_addr,
    output logic [BLK_W-1:0]   mem_wdata,
    input  logic               mem_ack,
    input  logic [BLK_W-1:0]   mem_rdata
);

    logic [ADDR_W-1:0] req_addr_q;
    logic              req_we_q;
    logic [7:0]        req_wdata_q;

    logic [SET_W-1:0]  cur_set;
    logic [TAG_W-1:0]  cur_tag;
    logic [OFF_W-1:0]  cur_off;

    logic [NUM_WAYS-1:0] way_hit;
    logic [NUM_WAYS-1:0] way_valid;
    logic [NUM_WAYS-1:0] way_dirty;
    logic [TAG_W-1:0]    way_tag [NUM_WAYS];
    logic [BLK_W-1:0]    way_blk [NUM_WAYS];

    cstate_e state;
    logic    accept, fill, vict_q, victim_c, vict_dirty, any_hit;
    logic [BLK_W-1:0] hit_blk;

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_addr_q  <= '0;
            req_we_q    <= 1'b0;
            req_wdata_q <= '0;
        end else if (accept) begin
            req_addr_q  <= cpu_addr;
            req_we_q    <= cpu_we;
            req_wdata_q <= cpu_wdata;
        end
    end

    assign cur_off = req_addr_q[OFF_W-1:0];
    assign cur_set = req_addr_q[OFF_W +: SET_W];
    assign cur_tag = req_addr_q[ADDR_W-1 -: TAG_W];

    // the two ways, compared in parallel
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        c2w_way #(
            .SETS (SETS),
            .TAG_W(TAG_W),
            .OFF_W(OFF_W),
            .BLK_W(BLK_W)
        ) way_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      (cur_set),
            .tag_i      (cur_tag),
            .fill_i     (fill && (vict_q == w[0])),
            .fill_data_i(mem_rdata),
            .wr_i       (cpu_done && req_we_q && way_hit[w]),
            .off_i      (cur_off),
            .byte_i     (req_wdata_q),
            .hit_o      (way_hit[w]),
            .valid_o    (way_valid[w]),
            .dirty_o    (way_dirty[w]),
            .tag_o      (way_tag[w]),
            .blk_o      (way_blk[w])
        );
    end

    assign any_hit = |way_hit;

    c2w_lru #(.SETS(SETS)) lru_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (cur_set),
        .v0_i       (way_valid[0]),
        .v1_i       (way_valid[1]),
        .touch_i    (cpu_done),
        .touch_way_i(way_hit[1]),
        .victim_o   (victim_c)
    );

    assign vict_dirty = way_valid[victim_c] && way_dirty[victim_c];

    c2w_ctrl ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_req_i   (cpu_req),
        .any_hit_i   (any_hit),
        .victim_i    (victim_c),
        .vict_dirty_i(vict_dirty),
        .mem_ack_i   (mem_ack),
        .state_o     (state),
        .ready_o     (cpu_ready),
        .accept_o    (accept),
        .done_o      (cpu_done),
        .first_hit_o (cpu_hit),
        .vict_way_o  (vict_q),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .fill_o      (fill)
    );

    // hit-way byte select
    assign hit_blk   = way_hit[1] ? way_blk[1] : way_blk[0];
    assign cpu_rdata = hit_blk[{cur_off, 3'b000} +: 8];

    // memory side: victim block on write-back, requested block on fetch
    assign mem_addr  = mem_we ? {way_tag[vict_q], cur_set} : {cur_tag, cur_set};
    assign mem_wdata = way_blk[vict_q];

    AST_NO_DUAL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(way_hit[0] && way_hit[1])); // R9

    AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && mem_ack) |=> any_hit); // R4

    AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOKUP && !any_hit && !(way_valid[0] && way_valid[1]))
            |-> !way_valid[victim_c]); // R6

    AST_LRU_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && way_valid[0] && way_valid[1])
            |=> (victim_c == !$past(way_hit[1]))); // R7

    AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (way_valid[vict_q] && way_dirty[vict_q])); // R8

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack)
            |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10

endmodule

// File: tb/cache2w_top_tb_top.sv
module cache2w_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_ready, cpu_done, cpu_hit;
    logic [7:0]  cpu_rdata;
    logic        mem_req, mem_we;
    logic [28:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;

    int checks = 0;
    int failures = 0;
    bit in_access = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    cache2w_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_req  (cpu_req),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready),
        .cpu_done (cpu_done),
        .cpu_hit  (cpu_hit),
        .cpu_rdata(cpu_rdata),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata)
    );

    // behavioural reference: per-way arrays, memory map, write-back queue
    bit          ref_v   [2][512];
    bit          ref_d   [2][512];
    bit [19:0]   ref_t   [2][512];
    bit [63:0]   ref_blk [2][512];
    bit          ref_lru [512];
    bit [63:0]   mem_map [bit [28:0]];
    bit [92:0]   wb_q [$];

    function automatic bit [63:0] mem_get(bit [28:0] a);
        if (mem_map.exists(a)) return mem_map[a];
        return {a, 6'h2a, a};
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model(input bit we, input bit [31:0] a, input bit [7:0] wd,
                         output bit h, output bit [7:0] b);
        int s, o, w;
        bit [19:0] t;
        s = int'(a[11:3]);
        o = int'(a[2:0]);
        t = a[31:12];
        h = 0;
        w = 0;
        if (ref_v[0][s] && ref_t[0][s] == t) begin h = 1; w = 0; end
        else if (ref_v[1][s] && ref_t[1][s] == t) begin h = 1; w = 1; end
        if (!h) begin
            if (!ref_v[0][s]) w = 0;
            else if (!ref_v[1][s]) w = 1;
            else w = int'(ref_lru[s]);
            if (ref_v[w][s] && ref_d[w][s]) begin
                mem_map[{ref_t[w][s], a[11:3]}] = ref_blk[w][s];
                wb_q.push_back({ref_t[w][s], a[11:3], ref_blk[w][s]});
            end
            ref_v[w][s]   = 1;
            ref_d[w][s]   = 0;
            ref_t[w][s]   = t;
            ref_blk[w][s] = mem_get(a[31:3]);
        end
        if (we) begin
            ref_blk[w][s][o*8 +: 8] = wd;
            ref_d[w][s] = 1;
        end
        b = ref_blk[w][s][o*8 +: 8];
        ref_lru[s] = (w == 0);
    endtask

    // memory responder and per-clock checks
    initial begin
        int cnt;
        logic [28:0] held_addr;
        logic        held_we;
        cnt = 0;
        held_addr = '0;
        held_we = 0;
        forever begin
            @(negedge clk);
            if (rst_n && cpu_done && !in_access)
                chk(0, "R2", "spurious done", 1, 0);
            if (mem_ack) begin
                mem_ack = 0;
                cnt = 0;
            end else if (rst_n && mem_req) begin
                if (cnt > 0)
                    chk(mem_addr == held_addr && mem_we == held_we, "R10",
                        "request changed before ack", longint'(mem_addr), longint'(held_addr));
                held_addr = mem_addr;
                held_we = mem_we;
                cnt++;
                if (cnt == 3) begin
                    mem_ack = 1;
                    if (mem_we) begin
                        if (wb_q.size() == 0) begin
                            chk(0, "R8", "unexpected write-back", longint'(mem_addr), 0);
                        end else begin
                            bit [92:0] e;
                            e = wb_q.pop_front();
                            chk(mem_addr == e[92:64], "R8", "write-back address",
                                longint'(mem_addr), longint'(e[92:64]));
                            chk(mem_wdata == e[63:0], "R8", "write-back data",
                                longint'(mem_wdata), longint'(e[63:0]));
                        end
                    end else begin
                        chk(wb_q.size() == 0, "R8", "fetch before write-back",
                            longint'(wb_q.size()), 0);
                        mem_rdata = mem_get(mem_addr);
                    end
                end
            end
        end
    end

    // one access: model prediction, then drive and compare
    task automatic access(bit we, bit [31:0] a, bit [7:0] wd, string req);
        bit exp_hit;
        bit [7:0] exp_b;
        int t;
        model(we, a, wd, exp_hit, exp_b);
        @(negedge clk);
        chk(cpu_ready == 1, req, "ready before request", longint'(cpu_ready), 1);
        in_access = 1;
        cpu_req = 1;
        cpu_we = we;
        cpu_addr = a;
        cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 0;
        t = 0;
        while (!cpu_done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(cpu_done == 1, req, "access timeout", longint'(t), 0);
        chk(cpu_hit == exp_hit, req, "hit flag", longint'(cpu_hit), longint'(exp_hit));
        if (exp_hit)
            chk(t == 0, req, "hit latency", longint'(t), 0);
        if (!we)
            chk(cpu_rdata == exp_b, req, "read byte", longint'(cpu_rdata), longint'(exp_b));
        @(negedge clk);
        in_access = 0;
    endtask

    function automatic bit [31:0] mk(bit [19:0] tag, bit [8:0] set, bit [2:0] off);
        return {tag, set, off};
    endfunction

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R3: reset state
        chk(cpu_ready == 1, "R3", "ready after reset", longint'(cpu_ready), 1);
        chk(mem_req == 0, "R3", "no memory request", longint'(mem_req), 0);
        chk(cpu_done == 0, "R3", "no done", longint'(cpu_done), 0);

        // R3: tag 0 / set 0 must miss after reset; R4 fill
        access(0, mk(20'h0, 9'd0, 3'd0), 8'h00, "R3");
        // R6: both empty -> way 0; R4 fetch
        access(0, mk(20'h1, 9'd5, 3'd2), 8'h00, "R4");
        // R2: hit at another offset
        access(0, mk(20'h1, 9'd5, 3'd7), 8'h00, "R2");
        // R6 / R1: second tag in the same set goes to the empty way
        access(0, mk(20'h2, 9'd5, 3'd1), 8'h00, "R6");
        access(0, mk(20'h1, 9'd5, 3'd3), 8'h00, "R1");
        access(0, mk(20'h2, 9'd5, 3'd4), 8'h00, "R1");
        // R7: touch tag1, tag2 becomes LRU; R5 write miss allocates
        access(0, mk(20'h1, 9'd5, 3'd0), 8'h00, "R7");
        access(1, mk(20'h3, 9'd5, 3'd6), 8'hA5, "R5");
        // R5: write hit, then read back with no memory traffic
        access(1, mk(20'h3, 9'd5, 3'd1), 8'h3C, "R5");
        access(0, mk(20'h3, 9'd5, 3'd6), 8'h00, "R5");
        access(0, mk(20'h3, 9'd5, 3'd1), 8'h00, "R5");
        // R8: make tag3 LRU and evict it (dirty write-back), then re-fetch
        access(0, mk(20'h1, 9'd5, 3'd5), 8'h00, "R7");
        access(0, mk(20'h4, 9'd5, 3'd0), 8'h00, "R8");
        access(0, mk(20'h3, 9'd5, 3'd6), 8'h00, "R8");
        access(0, mk(20'h3, 9'd5, 3'd1), 8'h00, "R9");

        // random phase over three sets and six tags
        for (int i = 0; i < 400; i++) begin
            bit [8:0] s;
            bit [19:0] tg;
            int k;
            k = $urandom_range(0, 2);
            s = (k == 0) ? 9'd5 : ((k == 1) ? 9'd6 : 9'd200);
            tg = 20'($urandom_range(0, 5));
            access(1'($urandom_range(0, 1)), mk(tg, s, 3'($urandom_range(0, 7))),
                   8'($urandom_range(0, 255)), "R7");
        end

        repeat (5) @(negedge clk);
        chk(wb_q.size() == 0, "R8", "pending write-backs", longint'(wb_q.size()), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule